// File: doc/BRIEF.md
# SDRAM Bring-Up and Refresh Sequencer

This block drives the command pins of one rank of 16-bit single-data-rate SDRAM, starting at reset. It first enables the clock, then waits out the power-up settling time. Next it closes every bank, runs a burst of auto-refresh cycles and programs the mode register. It then flags the memory as ready. After that point it owns only the periodic refresh. An internal interval timer raises a refresh request toward an external access arbiter. The refresh command goes out only once that arbiter acknowledges. The read and write paths belong to other logic.

All waits are set at elaboration from nanosecond parameters and the clock frequency. The frequency is first truncated to whole MHz. Each timing then becomes floor(MHz × ns / 1000) cycles, and a result of zero is raised to one cycle. The write-recovery count is derived here too and is published as a constant for the arbiter. It is the largest of three constraints.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, cke is low, the command is NOP {cs_n,ras_n,cas_n,we_n}=0111, init_done is low and refresh_req is low.
- R2: After reset, cke goes high and NOP is driven for exactly PWRUP_US×MHz cycles. This is 40000 cycles at the default 200 MHz.
- R3: The next cycle carries PRECHARGE (0010) with addr bit 10 high (addr = 0x400, ba = 0) to close all banks. It is followed by tRP = floor(MHz×18/1000) NOP cycles.
- R4: Eight AUTO REFRESH commands (0001) follow. Each one is followed by tRFC = floor(MHz×60/1000) NOP cycles.
- R5: Next comes LOAD MODE (0000) with ba = 0 and addr = CAS latency in bits [6:4] and burst code in bits [2:0], which is 0x030 by default. After tMRD NOP cycles, init_done rises and never falls again.
- R6: Every wait length is a truncating conversion floor(MHz×ns/1000), where MHz = floor(CLK_HZ/1e6). A zero result becomes one cycle.
- R7: wr_recovery_cyc equals max(tRDL, tRAS−tRCD, tRC−tRCD−tRP), each term being converted to cycles before the arithmetic. This is 6 at the defaults.
- R8: refresh_req rises exactly REFI cycles after init_done rises, and REFI cycles after each granted refresh command. REFI = floor(MHz×floor(64e6/8192)/1000) − 20, which is 1542 at the defaults.
- R9: refresh_req stays high until acknowledged. AUTO REFRESH is driven in the cycle after the one where refresh_req and refresh_ack are both high, and refresh_req is low in that same cycle.
- R10: refresh_ack while refresh_req is low has no effect: the command stays NOP.
- R11: Every non-NOP command is followed by at least one NOP cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_ack | input | 1 | Arbiter grant for a pending refresh |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Row/column/mode address bus |
| init_done | output | 1 | Memory is initialised and usable |
| refresh_req | output | 1 | Periodic refresh is due |
| wr_recovery_cyc | output | TWR_W | Derived write-recovery cycle count |

## Verification
The bench compares all four command pins, cke, the address and init_done in every cycle of the bring-up against a schedule it derives arithmetically. An off-by-one in any wait counter would therefore slide every later command by a cycle. A wrong tRP or tRFC truncation would show up the same way, and a dropped or extra initial refresh would shift the mode load. A missing bit 10 on the precharge, or a mode word with its fields swapped, shows on the address bus in that one cycle. During the refresh phase, acknowledges arrive after several different delays. The timing of the next request is checked exactly, so a counter that reloads at request time instead of grant time, or that is off by one, misses the expected cycle. Stray acknowledges sent between requests catch a design that refreshes without a pending request.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int ROW_W  = 12;
    localparam int BA_W   = 2;
    localparam int AP_BIT = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_PWRUP,
        ST_PRE,
        ST_W_RP,
        ST_AREF,
        ST_W_RFC,
        ST_LMR,
        ST_W_MRD,
        ST_IDLE,
        ST_RREF,
        ST_RWAIT
    } seq_state_e;

    typedef struct packed {
        logic             cke;
        sdram_cmd_e       cmd;
        logic [BA_W-1:0]  ba;
        logic [ROW_W-1:0] addr;
    } sdram_pins_t;

    // truncating nanosecond to cycle conversion
    function automatic int ns2clk(input int mhz, input int ns);
        return (mhz * ns) / 1000;
    endfunction

    function automatic int min1(input int c);
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return (m < 0) ? 0 : m;
    endfunction

endpackage

// File: rtl/sdram_wait_ctr.sv
module sdram_wait_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R6
    wait_reload_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (expired == ($past(load_val) == '0)))
        else $error("wait counter reload mismatch");
endmodule

// File: rtl/sdram_refi_ctr.sv
module sdram_refi_ctr #(
    parameter int INTERVAL = 1542,
    parameter int CNT_W    = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic issue,
    output logic req
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= RELOAD;
            req <= 1'b0;
        end else if (issue) begin
            cnt <= RELOAD;
            req <= 1'b0;
        end else if (cnt == '0) begin
            req <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !issue && run) |=> req)
        else $error("refresh request dropped without grant");
endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_seq_pkg::*;
#(
    parameter int               PWRUP_CYC      = 40000,
    parameter int               RP_CYC         = 3,
    parameter int               RFC_CYC        = 12,
    parameter int               MRD_CYC        = 1,
    parameter int               INIT_REFRESHES = 8,
    parameter int               CNT_W          = 16,
    parameter int               REF_W          = 4,
    parameter logic [ROW_W-1:0] MODE_WORD      = 12'h030
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wait_expired,
    input  logic             refresh_req,
    input  logic             refresh_ack,
    output logic             wait_load,
    output logic [CNT_W-1:0] wait_val,
    output logic             grant,
    output logic             init_done,
    output sdram_pins_t      pins
);
    seq_state_e       st, st_nxt;
    logic [REF_W-1:0] ref_left, ref_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_OFF;
            ref_left <= '0;
        end else begin
            st       <= st_nxt;
            ref_left <= ref_nxt;
        end
    end

    always_comb begin
        st_nxt    = st;
        ref_nxt   = ref_left;
        wait_load = 1'b0;
        wait_val  = '0;
        grant     = 1'b0;
        unique case (st)
            ST_OFF: begin
                wait_load = 1'b1;
                wait_val  = CNT_W'(PWRUP_CYC - 1);
                st_nxt    = ST_PWRUP;
            end
            ST_PWRUP: if (wait_expired) st_nxt = ST_PRE;
            ST_PRE: begin
                wait_load = 1'b1;
                wait_val  = CNT_W'(RP_CYC - 1);
                ref_nxt   = REF_W'(INIT_REFRESHES - 1);
                st_nxt    = ST_W_RP;
            end
            ST_W_RP: if (wait_expired) st_nxt = ST_AREF;
            ST_AREF: begin
                wait_load = 1'b1;
                wait_val  = CNT_W'(RFC_CYC - 1);
                st_nxt    = ST_W_RFC;
            end
            ST_W_RFC: begin
                if (wait_expired) begin
                    if (ref_left == '0) begin
                        st_nxt = ST_LMR;
                    end else begin
                        ref_nxt = ref_left - 1'b1;
                        st_nxt  = ST_AREF;
                    end
                end
            end
            ST_LMR: begin
                wait_load = 1'b1;
                wait_val  = CNT_W'(MRD_CYC - 1);
                st_nxt    = ST_W_MRD;
            end
            ST_W_MRD: if (wait_expired) st_nxt = ST_IDLE;
            ST_IDLE: begin
                if (refresh_req && refresh_ack) begin
                    grant  = 1'b1;
                    st_nxt = ST_RREF;
                end
            end
            ST_RREF: begin
                wait_load = 1'b1;
                wait_val  = CNT_W'(RFC_CYC - 1);
                st_nxt    = ST_RWAIT;
            end
            ST_RWAIT: if (wait_expired) st_nxt = ST_IDLE;
            default: st_nxt = ST_OFF;
        endcase
    end

    always_comb begin
        pins.cke  = (st != ST_OFF);
        pins.ba   = '0;
        pins.addr = '0;
        pins.cmd  = CMD_NOP;
        case (st)
            ST_PRE: begin
                pins.cmd          = CMD_PRE;
                pins.addr[AP_BIT] = 1'b1;
            end
            ST_AREF, ST_RREF: pins.cmd = CMD_AREF;
            ST_LMR: begin
                pins.cmd  = CMD_LMR;
                pins.addr = MODE_WORD;
            end
            default: ;
        endcase
    end

    assign init_done = (st == ST_IDLE) || (st == ST_RREF) || (st == ST_RWAIT);

    // R1
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !pins.cke |-> (pins.cmd == CMD_NOP))
        else $error("command issued with cke low");

    // R11
    cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pins.cmd != CMD_NOP) |=> (pins.cmd == CMD_NOP))
        else $error("back-to-back commands");

    // R5
    init_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done)
        else $error("init_done fell");

    // R9
    aref_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && pins.cmd == CMD_AREF) |-> $past(refresh_req && refresh_ack))
        else $error("refresh issued without request and grant");

    // R10
    no_req_no_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done && !refresh_req) |=> (pins.cmd != CMD_AREF))
        else $error("refresh issued without pending request");
endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
    import sdram_seq_pkg::*;
#(
    parameter int CLK_HZ         = 200_000_000,
    parameter int PWRUP_US       = 200,
    parameter int T_RCD_NS       = 18,
    parameter int T_RP_NS        = 18,
    parameter int T_RAS_NS       = 42,
    parameter int T_RC_NS        = 60,
    parameter int T_RFC_NS       = 60,
    parameter int T_RDL_NS       = 12,
    parameter int T_MRD_CYC      = 1,
    parameter int INIT_REFRESHES = 8,
    parameter int REFRESH_MS     = 64,
    parameter int REFRESH_ROWS   = 8192,
    parameter int REFI_MARGIN    = 20,
    parameter int CAS_LAT        = 3,
    parameter int BURST_CODE     = 0,
    parameter int TWR_W          = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             refresh_ack,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr,
    output logic             init_done,
    output logic             refresh_req,
    output logic [TWR_W-1:0] wr_recovery_cyc
);
    localparam int MHZ       = CLK_HZ / 1_000_000;
    localparam int PWRUP_CYC = min1(PWRUP_US * MHZ);
    localparam int RCD_CYC   = min1(ns2clk(MHZ, T_RCD_NS));
    localparam int RP_CYC    = min1(ns2clk(MHZ, T_RP_NS));
    localparam int RAS_CYC   = min1(ns2clk(MHZ, T_RAS_NS));
    localparam int RC_CYC    = min1(ns2clk(MHZ, T_RC_NS));
    localparam int RFC_CYC   = min1(ns2clk(MHZ, T_RFC_NS));
    localparam int RDL_CYC   = min1(ns2clk(MHZ, T_RDL_NS));
    localparam int MRD_CYC   = min1(T_MRD_CYC);
    localparam int REFI_NS   = (REFRESH_MS * 1_000_000) / REFRESH_ROWS;
    localparam int REFI_CYC  = min1(ns2clk(MHZ, REFI_NS) - REFI_MARGIN);
    localparam int TWR_CYC   = max3(RDL_CYC, RAS_CYC - RCD_CYC, RC_CYC - RCD_CYC - RP_CYC);
    localparam int WAIT_MAX  = (PWRUP_CYC > RFC_CYC) ? PWRUP_CYC : RFC_CYC;
    localparam int CNT_W     = $clog2(WAIT_MAX + 1);
    localparam int REFI_W    = $clog2(REFI_CYC + 1);
    localparam int REF_W     = $clog2(INIT_REFRESHES + 1);
    localparam logic [ROW_W-1:0] MODE_WORD =
        ROW_W'(((CAS_LAT & 7) << 4) | (BURST_CODE & 7));

    logic             wait_load, wait_expired, grant;
    logic [CNT_W-1:0] wait_val;
    sdram_pins_t      pins;

    sdram_wait_ctr #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .expired  (wait_expired)
    );

    sdram_refi_ctr #(.INTERVAL(REFI_CYC), .CNT_W(REFI_W)) u_refi (
        .clk   (clk),
        .rst   (rst),
        .run   (init_done),
        .issue (grant),
        .req   (refresh_req)
    );

    sdram_seq_fsm #(
        .PWRUP_CYC      (PWRUP_CYC),
        .RP_CYC         (RP_CYC),
        .RFC_CYC        (RFC_CYC),
        .MRD_CYC        (MRD_CYC),
        .INIT_REFRESHES (INIT_REFRESHES),
        .CNT_W          (CNT_W),
        .REF_W          (REF_W),
        .MODE_WORD      (MODE_WORD)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .wait_expired (wait_expired),
        .refresh_req  (refresh_req),
        .refresh_ack  (refresh_ack),
        .wait_load    (wait_load),
        .wait_val     (wait_val),
        .grant        (grant),
        .init_done    (init_done),
        .pins         (pins)
    );

    assign cke                        = pins.cke;
    assign {cs_n, ras_n, cas_n, we_n} = pins.cmd;
    assign ba                         = pins.ba;
    assign addr                       = pins.addr;
    assign wr_recovery_cyc            = TWR_W'(TWR_CYC);

    // R3
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> addr[AP_BIT])
        else $error("precharge without all-bank bit");
endmodule

// File: tb/sim_sdram_bringup_seq.sv
`timescale 1ns/1ps
module sim_sdram_bringup_seq;
    localparam int MHZ   = 200;
    localparam int P     = 200 * MHZ;
    localparam int RP    = (MHZ * 18) / 1000;
    localparam int RFC   = (MHZ * 60) / 1000;
    localparam int MRD   = 1;
    localparam int NREF  = 8;
    localparam int A0    = P + 2 + RP;
    localparam int M     = A0 + NREF * (1 + RFC);
    localparam int D     = M + MRD + 1;
    localparam int REFI  = (MHZ * (64000000 / 8192)) / 1000 - 20;
    localparam int C_RCD = (MHZ * 18) / 1000;
    localparam int C_RAS = (MHZ * 42) / 1000;
    localparam int C_RC  = (MHZ * 60) / 1000;
    localparam int C_RDL = (MHZ * 12) / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic refresh_ack = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [7:0]  wr_recovery_cyc;

    int nchk = 0;
    int nbad = 0;
    int n = 0;

    always #2.5 clk = ~clk;

    sdram_bringup_seq u0 (
        .clk(clk), .rst(rst), .refresh_ack(refresh_ack),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done), .refresh_req(refresh_req),
        .wr_recovery_cyc(wr_recovery_cyc)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, n, act, expv);
        end
    endtask

    function automatic logic [19:0] pk(input logic id, input logic ck,
                                       input logic [3:0] c, input logic [11:0] a);
        return {id, ck, c, 2'b00, a};
    endfunction

    function automatic logic [19:0] seen();
        return {init_done, cke, cs_n, ras_n, cas_n, we_n, ba, addr};
    endfunction

    task automatic step();
        @(negedge clk);
        n++;
    endtask

    task automatic chk_cmd(input logic [3:0] e, input string tag);
        check({cs_n, ras_n, cas_n, we_n} == e, tag, {cs_n, ras_n, cas_n, we_n}, e);
    endtask

    // one granted refresh; entered at the negedge of cycle start-1
    task automatic do_ref(input int start, input int dly, output int next_start);
        int r;
        step();
        check(refresh_req == 1'b1, "R8", refresh_req, 1);
        for (int i = 0; i < dly; i++) begin
            check(refresh_req == 1'b1, "R9", refresh_req, 1);
            chk_cmd(4'b0111, "R9");
            step();
        end
        check(refresh_req == 1'b1, "R9", refresh_req, 1);
        refresh_ack = 1'b1;
        step();
        chk_cmd(4'b0001, "R9");
        check(refresh_req == 1'b0, "R9", refresh_req, 0);
        refresh_ack = 1'b0;
        r = n;
        for (int i = 0; i < RFC; i++) begin
            step();
            chk_cmd(4'b0111, "R4");
        end
        while (n < r + REFI - 1) begin
            if (n == r + 40 + dly) refresh_ack = 1'b1;
            step();
            if (refresh_ack) begin
                refresh_ack = 1'b0;
                chk_cmd(4'b0111, "R10");
            end
        end
        check(refresh_req == 1'b0, "R8", refresh_req, 0);
        next_start = r + REFI;
    endtask

    initial begin
        logic [19:0] e;
        string tag;
        int nxt;
        repeat (4) @(negedge clk);
        check(cke == 1'b0, "R1", cke, 0);
        chk_cmd(4'b0111, "R1");
        check(init_done == 1'b0 && refresh_req == 1'b0, "R1",
              {init_done, refresh_req}, 0);
        rst = 1'b0;
        step();
        check(cke == 1'b1, "R2", cke, 1);
        check(wr_recovery_cyc == 8'(((C_RDL > C_RAS - C_RCD) ?
              ((C_RDL > C_RC - C_RCD - RP) ? C_RDL : C_RC - C_RCD - RP) :
              ((C_RAS - C_RCD > C_RC - C_RCD - RP) ? C_RAS - C_RCD : C_RC - C_RCD - RP))),
              "R7", wr_recovery_cyc, 6);
        // full bring-up schedule, one vector per cycle
        while (n <= D + 2) begin
            if (n <= P) begin
                e = pk(1'b0, 1'b1, 4'b0111, 12'h000); tag = "R2";
            end else if (n == P + 1) begin
                e = pk(1'b0, 1'b1, 4'b0010, 12'h400); tag = "R3";
            end else if (n < A0) begin
                e = pk(1'b0, 1'b1, 4'b0111, 12'h000); tag = "R3";
            end else if (n < M) begin
                e = (((n - A0) % (1 + RFC)) == 0) ?
                    pk(1'b0, 1'b1, 4'b0001, 12'h000) :
                    pk(1'b0, 1'b1, 4'b0111, 12'h000);
                tag = "R4";
            end else if (n == M) begin
                e = pk(1'b0, 1'b1, 4'b0000, 12'h030); tag = "R5";
            end else begin
                e = pk(n >= D, 1'b1, 4'b0111, 12'h000); tag = (n < D) ? "R6" : "R5";
            end
            check(seen() == e, tag, seen(), e);
            if (n >= D + 2) break;
            step();
        end
        // R10: stray acknowledge before the first request
        refresh_ack = 1'b1;
        step();
        refresh_ack = 1'b0;
        chk_cmd(4'b0111, "R10");
        check(refresh_req == 1'b0, "R10", refresh_req, 0);
        while (n < D + REFI - 1) step();
        check(refresh_req == 1'b0, "R8", refresh_req, 0);
        nxt = D + REFI;
        do_ref(nxt, 0, nxt);
        do_ref(nxt, 1, nxt);
        do_ref(nxt, 5, nxt);
        do_ref(nxt, 23, nxt);
        check(init_done == 1'b1, "R5", init_done, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule